// File: doc/BRIEF.md
# Free-Running Expiry Watchdog

This block is a watchdog timer that never stops counting. Software loads an 8-bit timeout count. The count goes down by one on each tick of the chosen time base, which is either one second or one minute. Writing the count again restarts the countdown, and this is how software keeps the system alive. When the count runs out, the block sets a sticky event flag. The counter then reloads from the stored count and carries on.

A system-reset pulse of fixed length comes only from the moment the event flag goes from clear to set, and only if the reset output enable is on at that moment. Turning the enable on after the flag is already set does not reset the system, and neither does a second expiry while the flag is still set. Software therefore clears the flag, by writing a one to it, before it enables the output.

A single-cycle `sec_tick` input marks each second. An internal divide-by-60 stage builds the minute base from it, and that stage is cleared on every write of the timeout count.

The reset-pulse sequencer has two states:
- `ST_IDLE`: no pulse is being driven.
- `ST_FIRE`: the pulse is being driven.

It has two transitions:
- `IDLE->FIRE`: taken on an expiry that raises the flag while the output is enabled.
- `FIRE->IDLE`: taken after `PULSE_LEN` cycles.

Top module: `freerun_wdt`

## Requirements
- R1: After reset the event flag and the reset output are 0, the output enable is off, the time base is seconds, and the stored count is `PRESET_RST` (default 60).
- R2: A write with `wr_sel`=0 stores `wr_data` as the count and restarts the countdown. With count N (N≥1), expiry happens on the Nth time-base tick after the write. A count write in the same cycle as a tick discards that tick.
- R3: After each expiry the counter reloads from the stored count and keeps running, so the next expiry comes N ticks later.
- R4: An expiry sets `event_flag` at the clock edge that ends the expiring tick. A write with `wr_sel`=3 and `wr_data[0]`=1 clears the flag. The same write with bit 0 = 0 has no effect. If an expiry coincides with a clear, the flag stays set.
- R5: `sys_rst_pulse` goes high in the same cycle the flag rises, and only if output enable (`wr_sel`=2, `wr_data[1]`) is 1 at that moment. Enabling the output while the flag is already set gives no pulse. An expiry while the flag is set gives no pulse.
- R6: Each reset pulse lasts exactly `PULSE_LEN` cycles (default 4).
- R7: A write with `wr_sel`=1 selects the time base from `wr_data[0]`: 1 selects seconds (every `sec_tick`), 0 selects minutes (every 60th `sec_tick`). The minute divider restarts on every count write.
- R8: A stored count of 0 expires on the next time-base tick.
- R9: The counter runs and the flag sets on expiry while the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, one per second |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 time base, 2 output enable, 3 event clear |
| wr_data | input | 8 | Write data |
| event_flag | output | 1 | Sticky expiry flag |
| sys_rst_pulse | output | 1 | System reset pulse |

## Verification
The countdown is exercised in four ways:
- Seconds base with counts of 3, 2 and 0: this separates off-by-one errors in the expiry point from errors in the reload.
- Minute base, run once from a fresh count write and once after a count write part-way through a minute: this shows whether the divider restarts on a count write.
- Flag already set, then output enabled or a second expiry: this distinguishes a reset gated by the flag's rising edge from one gated by the flag's level.
- Clear writes with bit 0 both high and low: these test the write-one-to-clear rule.

// File: rtl/freerun_wdt_pkg.sv
package freerun_wdt_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_TBASE = 2'd1,
        SEL_OUTEN = 2'd2,
        SEL_EVCLR = 2'd3
    } wsel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } pulse_st_e;

    localparam int TBASE_BIT = 0;
    localparam int OUTEN_BIT = 1;
    localparam int EVCLR_BIT = 0;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import freerun_wdt_pkg::*;
#(
    parameter int          CW         = 8,
    parameter logic [CW-1:0] PRESET_RST = 8'd60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] preset_q,
    output logic          load,
    output logic          tbase_sec_q,
    output logic          outen_q,
    output logic          clr_req
);
    wsel_e sel;
    assign sel     = wsel_e'(wr_sel);
    assign load    = wr_en && (sel == SEL_COUNT);
    assign clr_req = wr_en && (sel == SEL_EVCLR) && wr_data[EVCLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q    <= PRESET_RST;
            tbase_sec_q <= 1'b1;
            outen_q     <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_COUNT: preset_q    <= wr_data;
                SEL_TBASE: tbase_sec_q <= wr_data[TBASE_BIT];
                SEL_OUTEN: outen_q     <= wr_data[OUTEN_BIT];
                SEL_EVCLR: ;
            endcase
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic restart,
    output logic min_tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            assign min_tick = sec_tick;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pcnt_q;

            assign min_tick = sec_tick && (pcnt_q == LAST) && !restart;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                pcnt_q <= '0;
                else if (restart)          pcnt_q <= '0;
                else if (sec_tick) begin
                    if (pcnt_q == LAST)    pcnt_q <= '0;
                    else                   pcnt_q <= pcnt_q + 1'b1;
                end
            end
        end
    endgenerate

    // R7: a minute tick is always carried by a second tick
    p_min_sub_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> sec_tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] preset_q,
    input  logic [CW-1:0] cnt_rst,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = base_tick && !load && (cnt_q <= CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= cnt_rst;
        else if (load)       cnt_q <= load_val;
        else if (base_tick) begin
            if (cnt_q <= CW'(1)) cnt_q <= preset_q;
            else                 cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2: a count write discards the coinciding tick, so no expiry with it
    p_load_no_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !expire);
    // R3: an expiry leaves the reloaded count in the counter
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(preset_q)));
endmodule

// File: rtl/wdt_event.sv
module wdt_event
    import freerun_wdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    input  logic outen,
    output logic event_flag,
    output logic sys_rst_pulse
);
    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PULSE_LEN - 1);

    pulse_st_e     state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic          flag_q;
    logic          rise_ok;

    assign rise_ok = expire && !flag_q && outen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (expire)  flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rise_ok)          state_d = ST_FIRE;
            ST_FIRE: if (pcnt_q == PLAST)  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FIRE && state_d == ST_FIRE) pcnt_q <= pcnt_q + 1'b1;
            else                                          pcnt_q <= '0;
        end
    end

    always_comb begin
        sys_rst_pulse = (state_q == ST_FIRE);
        event_flag    = flag_q;
    end

    // R5: every pulse starts together with a rise of the flag under enable
    p_pulse_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_pulse) |-> ($rose(event_flag) && $past(outen)));
    // R4: the flag holds unless a clear is requested
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (event_flag && !clr_req) |=> event_flag);
    // R4: clear without coinciding expiry empties the flag
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expire) |=> !event_flag);
endmodule

// File: rtl/freerun_wdt.sv
module freerun_wdt #(
    parameter int          CW         = 8,
    parameter int          MIN_DIV    = 60,
    parameter int          PULSE_LEN  = 4,
    parameter logic [7:0]  PRESET_RST = 8'd60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic       event_flag,
    output logic       sys_rst_pulse
);
    localparam logic [CW-1:0] CNT_RST = CW'(PRESET_RST);

    logic [CW-1:0] preset_q;
    logic          load, tbase_sec, outen, clr_req;
    logic          min_tick, base_tick, expire;

    wdt_regs #(.CW(CW), .PRESET_RST(CNT_RST)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(CW'(wr_data)), .preset_q(preset_q), .load(load),
        .tbase_sec_q(tbase_sec), .outen_q(outen), .clr_req(clr_req)
    );

    wdt_prescaler #(.DIV(MIN_DIV)) presc_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .restart(load), .min_tick(min_tick)
    );

    assign base_tick = tbase_sec ? sec_tick : min_tick;

    wdt_counter #(.CW(CW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .load(load),
        .load_val(CW'(wr_data)), .preset_q(preset_q), .cnt_rst(CNT_RST),
        .expire(expire)
    );

    wdt_event #(.PULSE_LEN(PULSE_LEN)) evt_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req),
        .outen(outen), .event_flag(event_flag), .sys_rst_pulse(sys_rst_pulse)
    );
endmodule

// File: tb/freerun_wdt_tb.sv
module freerun_wdt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PLEN       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       event_flag, sys_rst_pulse;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freerun_wdt dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .event_flag(event_flag),
        .sys_rst_pulse(sys_rst_pulse)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // run n ticks, count how many cycles the reset pulse is seen
    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (sys_rst_pulse) pulses++;
            @(negedge clk);
            if (sys_rst_pulse) pulses++;
        end
    endtask

    task automatic measure_pulse(output int len);
        len = 0;
        while (sys_rst_pulse && len < 50) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        int p;
        check("R1 flag after reset", event_flag, 0);
        check("R1 pulse after reset", sys_rst_pulse, 0);
        ticks(59, p);
        check("R1 default count not yet expired", event_flag, 0);
        ticks(1, p);
        check("R1 default count 60 seconds expiry", event_flag, 1);
        check("R9 no pulse with output disabled", p, 0);
    endtask

    task automatic t_clear();
        wr(2'd3, 8'h00);
        check("R4 clear with bit0=0 ignored", event_flag, 1);
        wr(2'd3, 8'h01);
        check("R4 clear with bit0=1", event_flag, 0);
    endtask

    task automatic t_seconds_pulse();
        int p, len;
        wr(2'd2, 8'h02);
        wr(2'd0, 8'd3);
        ticks(2, p);
        check("R2 count 3 not expired after 2", event_flag, 0);
        tick();
        check("R2 count 3 expires on 3rd tick", event_flag, 1);
        check("R5 pulse with flag rise", sys_rst_pulse, 1);
        measure_pulse(len);
        check("R6 pulse length", len, PLEN);
        ticks(3, p);
        check("R5 no pulse on repeat expiry", p, 0);
        check("R4 flag still set", event_flag, 1);
    endtask

    task automatic t_reload();
        int p, len;
        wr(2'd0, 8'd2);
        wr(2'd3, 8'h01);
        ticks(1, p);
        check("R3 not expired after 1 of 2", event_flag, 0);
        tick();
        check("R3 expiry after 2", event_flag, 1);
        measure_pulse(len);
        check("R6 pulse length second run", len, PLEN);
        wr(2'd3, 8'h01);
        ticks(1, p);
        check("R3 reload not early", event_flag, 0);
        ticks(1, p);
        check("R3 reload expires again", event_flag, 1);
        check("R3 reload gives pulse", p > 0, 1);
    endtask

    task automatic t_restart();
        int p;
        wr(2'd0, 8'd3);
        wr(2'd3, 8'h01);
        ticks(2, p);
        wr(2'd0, 8'd3);
        ticks(2, p);
        check("R2 rewrite restarts countdown", event_flag, 0);
        // count write coinciding with a tick discards that tick
        @(negedge clk);
        sec_tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd1;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
        check("R2 tick with write ignored", event_flag, 0);
        ticks(1, p);
        check("R2 count 1 expires next tick", event_flag, 1);
    endtask

    task automatic t_zero();
        int p;
        wr(2'd0, 8'd0);
        wr(2'd3, 8'h01);
        check("R8 flag clear before tick", event_flag, 0);
        ticks(1, p);
        check("R8 count 0 expires next tick", event_flag, 1);
    endtask

    task automatic t_late_enable();
        int p;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd2);
        wr(2'd3, 8'h01);
        ticks(2, p);
        check("R9 flag sets with output disabled", event_flag, 1);
        check("R9 no pulse disabled", p, 0);
        wr(2'd2, 8'h02);
        ticks(4, p);
        check("R5 late enable gives no pulse", p, 0);
    endtask

    task automatic t_minutes();
        int p;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd1);
        wr(2'd3, 8'h01);
        ticks(30, p);
        wr(2'd0, 8'd1);
        ticks(59, p);
        check("R7 divider restarted by count write", event_flag, 0);
        ticks(1, p);
        check("R7 minute base expiry on 60th", event_flag, 1);
        wr(2'd0, 8'd2);
        wr(2'd3, 8'h01);
        ticks(119, p);
        check("R7 two minutes not early", event_flag, 0);
        ticks(1, p);
        check("R7 two minutes expiry", event_flag, 1);
        wr(2'd1, 8'h01);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset_state();
                t_clear();
                t_seconds_pulse();
                t_reload();
                t_restart();
                t_zero();
                t_late_enable();
                t_minutes();
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule